// File: doc/BRIEF.md
# Strided Vector Memory Address Generator

This block walks a vector load or store through a word-interleaved, multi-bank memory. A single start pulse carries a base address, a stride and a requested element count. The block then produces one element address at a time: the first is the base and each later one is the previous plus the stride, wrapping at the address width. Each address goes to the bank named by its low address bits. Every bank has one port and stays occupied for a fixed number of cycles after it accepts an access. At most one element is issued per cycle, on the shared address bus. An element whose bank is still occupied is held until that bank frees up, and no later element overtakes it.

For loads, the memory returns data on the shared data bus a fixed latency after issue. The block pairs each returned word with the element index it belongs to and raises a write strobe for the destination vector register. Because issue is in order and the latency is fixed, write-backs arrive in element order. A one-cycle done pulse marks the completion of the last element. A request for zero elements finishes without touching memory. Throughput follows the stride. A stride coprime to the bank count streams one element per cycle. A stride that is a multiple of the bank count serialises every access onto one bank.

Top module: `vec_stride_agen`

## Requirements
- R1: The address of element i is base + i*stride, taken modulo 2^ADDR_W. It is presented on `mem_addr`, with `mem_idx` = i, in the cycle `mem_req` is high.
- R2: The number of elements issued is vlen when vlen <= MAX_LEN, and MAX_LEN otherwise. Elements are issued in increasing index order, at most one per cycle. `mem_we` equals the store flag captured at start, and no request is made while `ready` is high.
- R3: `mem_bank` equals the low log2(NBANKS) bits of `mem_addr` (bank = address mod 16 by default).
- R4: A bank that accepts an access in cycle t accepts no other access before cycle t+BANK_LAT. The element waiting for it stalls issue, and the waiting element is issued in the first cycle its bank is free.
- R5: With free banks and an odd stride (coprime to 16 banks, 16 >= 11), element 0 issues in the cycle after start is accepted, and each later element issues in the next cycle.
- R6: With a stride that is a multiple of 16, successive elements issue exactly BANK_LAT (11) cycles apart.
- R7: For a load, `vr_we` is high exactly BANK_LAT cycles after an element's issue, with `vr_idx` equal to that element's index and `vr_data` equal to `mem_rdata` in that cycle. A store never raises `vr_we`.
- R8: `done` is a one-cycle pulse in the cycle the last element completes, which is BANK_LAT cycles after its issue. `ready` is low from the cycle after an accepted start through that cycle and is high in the next one. A start while `ready` is low is ignored.
- R9: A start with vlen = 0 makes no memory request, keeps `ready` high and pulses `done` in the next cycle.
- R10: In reset and after it, `ready` is high and `mem_req`, `vr_we` and `done` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin an operation (taken when ready) |
| is_store | input | 1 | 1 = store, 0 = load |
| base | input | ADDR_W | Address of element 0 |
| stride | input | ADDR_W | Address step between elements (wrapping) |
| vlen | input | LEN_W | Requested element count |
| ready | output | 1 | Idle, able to take a start |
| mem_req | output | 1 | Element access issued this cycle |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | ADDR_W | Shared word address bus |
| mem_bank | output | BANK_W | Target bank of the access |
| mem_idx | output | IDX_W | Element index of the access |
| mem_rdata | input | DATA_W | Shared read data bus |
| vr_we | output | 1 | Vector register write strobe |
| vr_idx | output | IDX_W | Element index to write |
| vr_data | output | DATA_W | Element data to write |
| done | output | 1 | Operation completion pulse |

## Verification
Two functions fall into the same cycle here. In one, a later element is issued while an earlier element's data is written back. In the other, the last element completes while a new start arrives. The first is provoked with vectors longer than the bank latency, under unit, odd, even and negative strides, so that issue and write-back overlap for many cycles. The second is provoked by driving start in the predicted done cycle and again in the middle of a busy operation. A behavioural model with per-bank free times and a queue of pending completions predicts every output on every cycle. A correct design issues and writes back independently in the overlapping cycles, and it ignores the colliding start with no change to the address stream.

// File: rtl/vec_stride_agen.sv
`timescale 1ns/1ps
module vec_stride_agen #(
  parameter int ADDR_W   = 16,
  parameter int DATA_W   = 32,
  parameter int NBANKS   = 16,
  parameter int BANK_LAT = 11,
  parameter int MAX_LEN  = 64,
  localparam int BANK_W  = $clog2(NBANKS),
  localparam int LEN_W   = $clog2(MAX_LEN + 1),
  localparam int IDX_W   = $clog2(MAX_LEN),
  localparam int TMR_W   = $clog2(BANK_LAT + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              is_store,
  input  logic [ADDR_W-1:0] base,
  input  logic [ADDR_W-1:0] stride,
  input  logic [LEN_W-1:0]  vlen,
  output logic              ready,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [BANK_W-1:0] mem_bank,
  output logic [IDX_W-1:0]  mem_idx,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              vr_we,
  output logic [IDX_W-1:0]  vr_idx,
  output logic [DATA_W-1:0] vr_data,
  output logic              done
);

  logic              busy, active, store_q, zero_done_q;
  logic [ADDR_W-1:0] addr_q, stride_q;
  logic [LEN_W-1:0]  rem_q;
  logic [IDX_W-1:0]  idx_q;
  logic [TMR_W-1:0]  tmr [NBANKS];

  logic              pv    [BANK_LAT];
  logic              plast [BANK_LAT];
  logic              pload [BANK_LAT];
  logic [IDX_W-1:0]  pidx  [BANK_LAT];

  wire [BANK_W-1:0] cur_bank = addr_q[BANK_W-1:0];
  wire              issue    = active && (tmr[cur_bank] == '0);
  wire              accept   = start && !busy;
  wire [LEN_W-1:0]  eff_len  = (vlen > LEN_W'(MAX_LEN)) ? LEN_W'(MAX_LEN) : vlen;
  wire              tail_v   = pv[BANK_LAT-1];
  wire              tail_end = tail_v && plast[BANK_LAT-1];

  assign ready    = !busy;
  assign mem_req  = issue;
  assign mem_we   = store_q;
  assign mem_addr = addr_q;
  assign mem_bank = cur_bank;
  assign mem_idx  = idx_q;
  assign vr_we    = tail_v && pload[BANK_LAT-1];
  assign vr_idx   = pidx[BANK_LAT-1];
  assign vr_data  = mem_rdata;
  assign done     = zero_done_q || tail_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy        <= 1'b0;
      active      <= 1'b0;
      store_q     <= 1'b0;
      zero_done_q <= 1'b0;
      addr_q      <= '0;
      stride_q    <= '0;
      rem_q       <= '0;
      idx_q       <= '0;
    end else begin
      zero_done_q <= accept && (eff_len == '0);
      if (accept) begin
        busy     <= (eff_len != '0);
        active   <= (eff_len != '0);
        store_q  <= is_store;
        addr_q   <= base;
        stride_q <= stride;
        rem_q    <= eff_len;
        idx_q    <= '0;
      end else begin
        if (tail_end) busy <= 1'b0;
        if (issue) begin
          addr_q <= addr_q + stride_q;
          idx_q  <= idx_q + 1'b1;
          rem_q  <= rem_q - 1'b1;
          if (rem_q == LEN_W'(1)) active <= 1'b0;
        end
      end
    end
  end

  for (genvar b = 0; b < NBANKS; b++) begin : g_bank
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                 tmr[b] <= '0;
      else if (issue && cur_bank == BANK_W'(b))   tmr[b] <= TMR_W'(BANK_LAT - 1);
      else if (tmr[b] != '0)                      tmr[b] <= tmr[b] - 1'b1;
    end
  end

  for (genvar k = 0; k < BANK_LAT; k++) begin : g_stage
    if (k == 0) begin : g_head
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          pv[0] <= 1'b0; plast[0] <= 1'b0; pload[0] <= 1'b0; pidx[0] <= '0;
        end else begin
          pv[0]    <= issue;
          plast[0] <= (rem_q == LEN_W'(1));
          pload[0] <= !store_q;
          pidx[0]  <= idx_q;
        end
      end
    end else begin : g_body
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          pv[k] <= 1'b0; plast[k] <= 1'b0; pload[k] <= 1'b0; pidx[k] <= '0;
        end else begin
          pv[k]    <= pv[k-1];
          plast[k] <= plast[k-1];
          pload[k] <= pload[k-1];
          pidx[k]  <= pidx[k-1];
        end
      end
    end
  end

  logic [ADDR_W-1:0] last_addr;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       last_addr <= '0;
    else if (mem_req) last_addr <= mem_addr;
  end

  assert_addr_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_idx != '0) |-> (mem_addr == last_addr + stride_q));

  assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> !mem_req);

  if (BANK_LAT > 1) begin : g_gap
    assert_bank_gap_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && $past(mem_req)) |-> (mem_bank != $past(mem_bank)));
  end

  assert_wb_order_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (vr_we && $past(vr_we)) |-> (vr_idx == $past(vr_idx) + 1'b1));

  assert_done_ready_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> ready);

endmodule

// File: tb/vec_stride_agen_test.sv
`timescale 1ns/1ps
module vec_stride_agen_test;
  localparam int AW = 16, DW = 32, NB = 16, LAT = 11, ML = 64;
  localparam int LW = $clog2(ML + 1), IW = $clog2(ML), BW = $clog2(NB);

  logic clk = 0, rst_n = 0;
  logic start = 0, is_store = 0;
  logic [AW-1:0] base = 0, stride = 0;
  logic [LW-1:0] vlen = 0;
  logic ready, mem_req, mem_we, vr_we, done;
  logic [AW-1:0] mem_addr;
  logic [BW-1:0] mem_bank;
  logic [IW-1:0] mem_idx, vr_idx;
  logic [DW-1:0] mem_rdata = 0, vr_data;

  vec_stride_agen uut (.clk(clk), .rst_n(rst_n), .start(start), .is_store(is_store),
    .base(base), .stride(stride), .vlen(vlen), .ready(ready), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_bank(mem_bank), .mem_idx(mem_idx),
    .mem_rdata(mem_rdata), .vr_we(vr_we), .vr_idx(vr_idx), .vr_data(vr_data), .done(done));

  always #2 clk = ~clk;

  int checks = 0, errors = 0, cyc = 0;
  bit finished = 0;

  // next-cycle stimulus
  bit nx_start = 0, nx_store = 0;
  int nx_base = 0, nx_stride = 0, nx_len = 0;

  // reference model
  bit m_busy = 0, m_active = 0, m_store = 0, m_zd = 0;
  int m_addr = 0, m_stride = 0, m_rem = 0, m_idx = 0;
  int bfree [NB];
  int q_due[$], q_idx[$], q_last[$], q_load[$], q_addr[$];
  int iss[$];
  int done_cnt = 0;

  function automatic logic [DW-1:0] mkdata(int a);
    return {a[15:0], a[15:0] ^ 16'h5A3C};
  endfunction

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  task automatic step();
    bit e_req, e_wb, e_done, front, rdy;
    int b, n;
    @(negedge clk);
    front = (q_due.size() > 0) && (q_due[0] == cyc);
    mem_rdata = (front && q_load[0] != 0) ? mkdata(q_addr[0]) : '0;
    #1;
    e_req  = m_active && (bfree[m_addr % NB] <= cyc);
    e_wb   = front && q_load[0] != 0;
    e_done = (front && q_last[0] != 0) || m_zd;
    chk(ready == !m_busy, "R8", "ready", ready, !m_busy);
    chk(mem_req == e_req, "R4", "mem_req", mem_req, e_req);
    if (e_req && mem_req) begin
      chk(mem_addr == m_addr[AW-1:0], "R1", "mem_addr", mem_addr, m_addr);
      chk(mem_idx == m_idx[IW-1:0], "R2", "mem_idx", mem_idx, m_idx);
      chk(mem_we == m_store, "R2", "mem_we", mem_we, m_store);
      chk(mem_bank == m_addr[BW-1:0], "R3", "mem_bank", mem_bank, m_addr % NB);
    end
    chk(vr_we == e_wb, "R7", "vr_we", vr_we, e_wb);
    if (e_wb && vr_we) begin
      chk(vr_idx == q_idx[0][IW-1:0], "R7", "vr_idx", vr_idx, q_idx[0]);
      chk(vr_data == mkdata(q_addr[0]), "R7", "vr_data", vr_data, mkdata(q_addr[0]));
    end
    chk(done == e_done, "R8", "done", done, e_done);
    if (mem_req) iss.push_back(cyc);
    if (done) done_cnt++;
    // drive inputs for the coming edge
    start = nx_start; is_store = nx_store;
    base = nx_base[AW-1:0]; stride = nx_stride[AW-1:0]; vlen = nx_len[LW-1:0];
    // model transition at that edge
    rdy = !m_busy;
    if (e_req) begin
      b = m_addr % NB;
      bfree[b] = cyc + LAT;
      q_due.push_back(cyc + LAT); q_idx.push_back(m_idx);
      q_last.push_back(m_rem == 1); q_load.push_back(!m_store); q_addr.push_back(m_addr);
      m_addr = (m_addr + m_stride) & 16'hFFFF;
      m_idx++; m_rem--;
      if (m_rem == 0) m_active = 0;
    end
    if (front) begin
      if (q_last[0] != 0) m_busy = 0;
      void'(q_due.pop_front()); void'(q_idx.pop_front()); void'(q_last.pop_front());
      void'(q_load.pop_front()); void'(q_addr.pop_front());
    end
    m_zd = 0;
    if (nx_start && rdy) begin
      n = (nx_len > ML) ? ML : nx_len;
      if (n == 0) m_zd = 1;
      else begin
        m_busy = 1; m_active = 1; m_store = nx_store;
        m_addr = nx_base & 16'hFFFF; m_stride = nx_stride & 16'hFFFF;
        m_rem = n; m_idx = 0;
      end
    end
    cyc++;
  endtask

  // returns start cycle of the op
  task automatic run_op(int b, int s, int n, bit st, bit poke_mid, bit poke_done, output int s0);
    int k = 0;
    iss.delete(); done_cnt = 0;
    s0 = cyc;
    nx_start = 1; nx_base = b; nx_stride = s; nx_len = n; nx_store = st;
    step();
    nx_start = 0;
    while (m_busy || m_zd) begin
      k++;
      nx_start = 0;
      if (poke_mid && k == 3) begin
        nx_start = 1; nx_base = 16'h7777; nx_stride = 5; nx_len = 9;
      end
      if (poke_done && q_due.size() > 0 && q_due[0] == cyc && q_last[0] != 0) begin
        nx_start = 1; nx_base = 16'h1234; nx_stride = 1; nx_len = 4;
      end
      step();
    end
    nx_start = 0;
    repeat (3) step();
  endtask

  initial begin
    int s0;
    bit ok;
    for (int i = 0; i < NB; i++) bfree[i] = 0;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(ready == 1'b1, "R10", "ready in reset", ready, 1);
    chk(mem_req == 1'b0, "R10", "mem_req in reset", mem_req, 0);
    chk(vr_we == 1'b0 && done == 1'b0, "R10", "vr_we/done in reset", {vr_we, done}, 0);
    rst_n = 1;
    repeat (2) step();

    // R5: unit stride streams, issue overlaps write-back
    run_op(16'h0100, 1, 20, 0, 0, 0, s0);
    chk(iss.size() == 20, "R2", "issue count stride 1", iss.size(), 20);
    ok = (iss.size() > 0) && (iss[0] == s0 + 1);
    for (int i = 1; i < iss.size(); i++) if (iss[i] != iss[i-1] + 1) ok = 0;
    chk(ok, "R5", "back-to-back issue stride 1", ok, 1);
    chk(done_cnt == 1, "R8", "single done pulse", done_cnt, 1);

    // R6: same-bank stride, start poked in the done cycle
    run_op(16'h0203, 16, 5, 0, 0, 1, s0);
    chk(iss.size() == 5, "R2", "issue count stride 16", iss.size(), 5);
    ok = 1;
    for (int i = 1; i < iss.size(); i++) if (iss[i] - iss[i-1] != LAT) ok = 0;
    chk(ok, "R6", "stride 16 issue spacing", ok, 1);

    // R4: even stride, 8 banks in use, stalls
    run_op(16'h0040, 2, 20, 0, 0, 0, s0);
    chk(iss.size() == 20, "R4", "issue count stride 2", iss.size(), 20);
    chk(iss.size() > 8 && iss[8] == iss[0] + LAT, "R4", "element 8 waits for bank",
        iss.size() > 8 ? iss[8] - iss[0] : -1, LAT);

    // R8: store with a start poked mid-operation, address wrap
    run_op(16'hFFF0, 3, 12, 1, 1, 0, s0);
    chk(iss.size() == 12, "R8", "poked start ignored (count)", iss.size(), 12);

    // R1: negative stride wraps below zero
    run_op(5, 16'hFFFF, 10, 0, 0, 0, s0);
    chk(iss.size() == 10, "R1", "issue count negative stride", iss.size(), 10);

    // R9: zero length
    run_op(16'h0500, 1, 0, 0, 0, 0, s0);
    chk(iss.size() == 0, "R9", "no request for zero length", iss.size(), 0);
    chk(done_cnt == 1, "R9", "done for zero length", done_cnt, 1);

    // R2: over-length request clipped to capacity
    run_op(16'h0900, 5, 100, 0, 0, 0, s0);
    chk(iss.size() == ML, "R2", "length clipped", iss.size(), ML);

    // R6: stride 32 also single bank
    run_op(16'h0011, 32, 3, 1, 0, 0, s0);
    ok = (iss.size() == 3) && (iss[1] - iss[0] == LAT) && (iss[2] - iss[1] == LAT);
    chk(ok, "R6", "stride 32 issue spacing", ok, 1);

    if (!finished) begin
      finished = 1;
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule